// File: doc/BRIEF.md
# MMU fault status and fault address registers

This block holds the result of the most recent failed address translation. When the page-table walker raises its fault strobe, the block records four things. The level at which the walk stopped and the fault type go into a status word, together with the access index (write, fetch and supervisor flags). The full faulting virtual address goes into a separate address register. If a second fault arrives before software has read the status word, the earlier contents collapse to a single overflow flag, and the new fields are merged on top of that flag.

On every fault the block also decides what happens to the access:
- Normally it raises a one-cycle exception request, typed as an instruction fault for a fetch and as a data fault for anything else.
- When the no-fault enable is set, or traps are disabled, it raises no exception. Instead it pulses a full-permission grant, so the access completes with read, write and execute rights.

Software reads either register through a small read port. A read of the status word clears it.

Top module: `mmu_fault_regs`

## Requirements
- R1: After reset, the status word and the address register both read as zero, and neither the exception request nor the grant is asserted.
- R2: A fault taken with a zero status word sets the status to the following fields, with all other bits zero: bit 1 = 1 (address valid), bits [4:2] = fault type, bits [7:5] = access index, bits [9:8] = walk level.
- R3: A fault taken while the status word is nonzero and not being read in that cycle first replaces the status word with 1 (bit 0, overflow). The R2 fields are then ORed into it.
- R4: Every fault loads the address register with the complete faulting virtual address, whether or not the status word is nonzero.
- R5: A read with select 0 returns the status word and clears it to zero at the next clock edge. A read with select 1 returns the address register and changes nothing.
- R6: When the no-fault enable is 0 and trap enable is 1, a fault makes the exception request high for exactly the cycle after the strobe. Its type bit is 1 (instruction) when access index bit 1 (fetch) is set, and 0 (data) otherwise.
- R7: When the no-fault enable is 1 or trap enable is 0, a fault raises no exception. The grant output is high for exactly the cycle after the strobe instead. This covers a user-mode permission fault with no-fault enabled.
- R8: When a status read and a fault fall in the same cycle, the read returns the old status. The new fault is then recorded as though the status word had been zero, so no overflow flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_vld | input | 1 | Walker fault strobe, one cycle per fault |
| fault_lvl | input | 2 | Table level at which the walk stopped |
| fault_type | input | 3 | Fault type code from the walker |
| fault_ai | input | 3 | Access index: bit 2 write, bit 1 fetch, bit 0 supervisor |
| fault_vaddr | input | 32 | Faulting virtual address |
| nf_en | input | 1 | No-fault enable from the control register |
| trap_en | input | 1 | Processor trap-enable state |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 1 | Read select: 0 status word, 1 address register |
| rd_data | output | 32 | Read data for the selected register |
| exc_req | output | 1 | One-cycle exception request |
| exc_instr | output | 1 | Exception type: 1 instruction, 0 data |
| grant_full | output | 1 | One-cycle full-permission grant for a suppressed fault |

## Verification
A fault strobe and a clearing read of the status word can land in the same cycle. Both want to write the status word, and the result decides whether the overflow flag appears.

The bench provokes this case in a fixed way:
1. It lets a first fault leave the status word nonzero.
2. It then drives a second fault and a status read on the same clock edge.
3. It checks that the read data is the first fault's status.
4. It reads the status again and expects exactly the second fault's fields, with bit 0 clear.

Overflow is checked separately in two ways: with back-to-back faults, and with faults that have idle cycles between them.

// File: rtl/mmu_fault_pkg.sv
package mmu_fault_pkg;
  localparam int DATA_W = 32;
  localparam int LVL_W  = 2;
  localparam int FT_W   = 3;
  localparam int AI_W   = 3;

  // status word layout: overflow, address valid, then type, access, level
  localparam int OVF_BIT  = 0;
  localparam int AVAL_BIT = 1;
  localparam int FT_LSB   = 2;
  localparam int AI_LSB   = FT_LSB + FT_W;
  localparam int LVL_LSB  = AI_LSB + AI_W;

  // access index bit that flags an instruction fetch
  localparam int AI_FETCH_BIT = 1;

  typedef enum logic {
    EXC_DATA  = 1'b0,
    EXC_INSTR = 1'b1
  } exc_kind_e;
endpackage

// File: rtl/mff_status.sv
module mff_status
  import mmu_fault_pkg::*;
#(
  parameter int W  = DATA_W,
  parameter int LW = LVL_W,
  parameter int TW = FT_W,
  parameter int AW = AI_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fault_vld,
  input  logic [LW-1:0] lvl,
  input  logic [TW-1:0] ftype,
  input  logic [AW-1:0] ai,
  input  logic          clr,
  output logic [W-1:0]  fsr_q
);
  logic [W-1:0] base;
  logic [W-1:0] fields;
  logic [W-1:0] fsr_d;
  logic         fsr_en;

  always_comb begin
    fields = '0;
    fields[AVAL_BIT]          = 1'b1;
    fields[FT_LSB  +: TW]     = ftype;
    fields[AI_LSB  +: AW]     = ai;
    fields[LVL_LSB +: LW]     = lvl;
    // a read in the same cycle consumes the old value first
    base   = clr ? '0 : fsr_q;
    fsr_en = fault_vld | clr;
    if (fault_vld) begin
      fsr_d = fields;
      if (|base) fsr_d[OVF_BIT] = 1'b1;
    end else begin
      fsr_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fsr_q <= '0;
    else if (fsr_en) fsr_q <= fsr_d;
  end
endmodule

// File: rtl/mff_addr.sv
module mff_addr
  import mmu_fault_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fault_vld,
  input  logic [W-1:0] vaddr,
  output logic [W-1:0] far_q
);
  logic [W-1:0] far_d;
  logic         far_en;

  always_comb begin
    far_en = fault_vld;
    far_d  = vaddr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      far_q <= '0;
    else if (far_en) far_q <= far_d;
  end
endmodule

// File: rtl/mff_exc.sv
module mff_exc
  import mmu_fault_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      fault_vld,
  input  logic      is_fetch,
  input  logic      nf_en,
  input  logic      trap_en,
  output logic      exc_req_q,
  output exc_kind_e exc_kind_q,
  output logic      grant_q
);
  logic      raise;
  logic      exc_req_d;
  logic      grant_d;
  exc_kind_e exc_kind_d;

  always_comb begin
    raise      = fault_vld & trap_en & ~nf_en;
    exc_req_d  = raise;
    grant_d    = fault_vld & ~raise;
    exc_kind_d = raise ? (is_fetch ? EXC_INSTR : EXC_DATA) : exc_kind_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_req_q  <= 1'b0;
      grant_q    <= 1'b0;
      exc_kind_q <= EXC_DATA;
    end else begin
      exc_req_q  <= exc_req_d;
      grant_q    <= grant_d;
      exc_kind_q <= exc_kind_d;
    end
  end
endmodule

// File: rtl/mmu_fault_regs.sv
module mmu_fault_regs
  import mmu_fault_pkg::*;
#(
  parameter int W  = DATA_W,
  parameter int LW = LVL_W,
  parameter int TW = FT_W,
  parameter int AW = AI_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fault_vld,
  input  logic [LW-1:0] fault_lvl,
  input  logic [TW-1:0] fault_type,
  input  logic [AW-1:0] fault_ai,
  input  logic [W-1:0]  fault_vaddr,
  input  logic          nf_en,
  input  logic          trap_en,
  input  logic          rd_en,
  input  logic          rd_sel,
  output logic [W-1:0]  rd_data,
  output logic          exc_req,
  output logic          exc_instr,
  output logic          grant_full
);
  logic [W-1:0] fsr_q;
  logic [W-1:0] far_q;
  logic         rd_clr;
  exc_kind_e    kind_q;

  assign rd_clr    = rd_en & ~rd_sel;
  assign rd_data   = rd_sel ? far_q : fsr_q;
  assign exc_instr = (kind_q == EXC_INSTR);

  mff_status #(.W(W), .LW(LW), .TW(TW), .AW(AW)) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .fault_vld (fault_vld),
    .lvl       (fault_lvl),
    .ftype     (fault_type),
    .ai        (fault_ai),
    .clr       (rd_clr),
    .fsr_q     (fsr_q)
  );

  mff_addr #(.W(W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .fault_vld (fault_vld),
    .vaddr     (fault_vaddr),
    .far_q     (far_q)
  );

  mff_exc u_exc (
    .clk        (clk),
    .rst_n      (rst_n),
    .fault_vld  (fault_vld),
    .is_fetch   (fault_ai[AI_FETCH_BIT]),
    .nf_en      (nf_en),
    .trap_en    (trap_en),
    .exc_req_q  (exc_req),
    .exc_kind_q (kind_q),
    .grant_q    (grant_full)
  );
endmodule

// File: rtl/mmu_fault_regs_chk.sv
module mmu_fault_regs_chk
  import mmu_fault_pkg::*;
#(
  parameter int W  = DATA_W,
  parameter int AW = AI_W
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fault_vld,
  input logic [AW-1:0] fault_ai,
  input logic [W-1:0]  fault_vaddr,
  input logic          nf_en,
  input logic          trap_en,
  input logic          rd_en,
  input logic          rd_sel,
  input logic [W-1:0]  fsr_q,
  input logic [W-1:0]  far_q,
  input logic          exc_req,
  input logic          exc_instr,
  input logic          grant_full
);
  p_addr_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fault_vld |=> far_q == $past(fault_vaddr));

  p_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_vld && fsr_q != '0 && !(rd_en && !rd_sel)) |=> fsr_q[OVF_BIT] && fsr_q[AVAL_BIT]);

  p_read_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_sel && !fault_vld) |=> fsr_q == '0);

  p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_vld |=> $stable(far_q));

  p_exc_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> ($past(fault_vld) && exc_instr == $past(fault_ai[AI_FETCH_BIT])));

  p_suppress_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_vld && (nf_en || !trap_en)) |=> grant_full && !exc_req);

  p_same_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_vld && rd_en && !rd_sel) |=> !fsr_q[OVF_BIT] && fsr_q[AVAL_BIT]);

  p_status_fields_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fault_vld |=> fsr_q[AVAL_BIT]);
endmodule

bind mmu_fault_regs mmu_fault_regs_chk #(.W(W), .AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fault_vld   (fault_vld),
  .fault_ai    (fault_ai),
  .fault_vaddr (fault_vaddr),
  .nf_en       (nf_en),
  .trap_en     (trap_en),
  .rd_en       (rd_en),
  .rd_sel      (rd_sel),
  .fsr_q       (fsr_q),
  .far_q       (far_q),
  .exc_req     (exc_req),
  .exc_instr   (exc_instr),
  .grant_full  (grant_full)
);

// File: tb/mmu_fault_regs_bench.sv
module mmu_fault_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        fault_vld;
  logic [1:0]  fault_lvl;
  logic [2:0]  fault_type;
  logic [2:0]  fault_ai;
  logic [31:0] fault_vaddr;
  logic        nf_en;
  logic        trap_en;
  logic        rd_en;
  logic        rd_sel;
  logic [31:0] rd_data;
  logic        exc_req;
  logic        exc_instr;
  logic        grant_full;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  mmu_fault_regs u_mmu_fault_regs (.*);

  // {lvl[2], type[3], ai[3], nf, te, vaddr[32]}
  localparam int NV = 8;
  localparam logic [41:0] VEC [NV] = '{
    {2'd3, 3'd1, 3'b001, 1'b0, 1'b1, 32'h1234_5678},
    {2'd0, 3'd4, 3'b010, 1'b0, 1'b1, 32'hFFFF_F000},
    {2'd2, 3'd2, 3'b100, 1'b0, 1'b1, 32'h8000_0004},
    {2'd1, 3'd3, 3'b000, 1'b1, 1'b1, 32'h0040_2000},
    {2'd3, 3'd1, 3'b011, 1'b0, 1'b0, 32'hDEAD_BEEF},
    {2'd2, 3'd4, 3'b110, 1'b1, 1'b0, 32'h0000_0001},
    {2'd1, 3'd7, 3'b111, 1'b0, 1'b1, 32'hA5A5_5A5A},
    {2'd0, 3'd0, 3'b101, 1'b1, 1'b1, 32'h7FFF_FFFF}
  };

  function automatic logic [31:0] fields(logic [1:0] l, logic [2:0] t, logic [2:0] a);
    return {22'd0, l, a, t, 2'b10};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive_fault(logic [1:0] l, logic [2:0] t, logic [2:0] a,
                             logic nf, logic te, logic [31:0] va);
    fault_vld = 1'b1; fault_lvl = l; fault_type = t; fault_ai = a;
    nf_en = nf; trap_en = te; fault_vaddr = va;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; fault_vld = 1'b0; fault_lvl = '0; fault_type = '0; fault_ai = '0;
    fault_vaddr = '0; nf_en = 1'b0; trap_en = 1'b1; rd_en = 1'b0; rd_sel = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    rd_sel = 1'b0; #1 check("R1 status", rd_data, 32'h0);
    rd_sel = 1'b1; #1 check("R1 address", rd_data, 32'h0);
    check("R1 exc/grant", {30'd0, exc_req, grant_full}, 32'h0);

    // table-driven faults from a cleared status
    for (int i = 0; i < NV; i++) begin
      logic [1:0] l; logic [2:0] t; logic [2:0] a; logic nf; logic te; logic [31:0] va;
      logic ex;
      {l, t, a, nf, te, va} = VEC[i];
      ex = te & ~nf;
      @(negedge clk);
      drive_fault(l, t, a, nf, te, va);
      @(negedge clk);
      fault_vld = 1'b0;
      check(ex ? "R6 exc_req" : "R7 exc_req", {31'd0, exc_req}, {31'd0, ex});
      check("R7 grant", {31'd0, grant_full}, {31'd0, ~ex});
      if (ex) check("R6 type", {31'd0, exc_instr}, {31'd0, a[1]});
      rd_en = 1'b1; rd_sel = 1'b1;
      #1 check("R4 address", rd_data, va);
      @(negedge clk);
      check("R6 pulse width", {30'd0, exc_req, grant_full}, 32'h0);
      check("R5 address read keeps", rd_data, va);
      rd_sel = 1'b0;
      #1 check("R2 status", rd_data, fields(l, t, a));
      @(negedge clk);
      check("R5 status cleared", rd_data, 32'h0);
      rd_en = 1'b0;
    end

    // R3 overflow with idle gap
    @(negedge clk); drive_fault(2'd1, 3'd2, 3'b001, 1'b0, 1'b1, 32'h0000_1000);
    @(negedge clk); fault_vld = 1'b0;
    @(negedge clk); drive_fault(2'd3, 3'd5, 3'b100, 1'b0, 1'b1, 32'h0000_2000);
    @(negedge clk); fault_vld = 1'b0; rd_sel = 1'b0;
    #1 check("R3 overflow gap", rd_data, fields(2'd3, 3'd5, 3'b100) | 32'h1);
    rd_sel = 1'b1; #1 check("R4 second address", rd_data, 32'h0000_2000);

    // R8 read and fault in one cycle: status nonzero now
    @(negedge clk);
    drive_fault(2'd2, 3'd1, 3'b010, 1'b0, 1'b1, 32'h0000_3000);
    rd_en = 1'b1; rd_sel = 1'b0;
    #1 check("R8 read returns old", rd_data, fields(2'd3, 3'd5, 3'b100) | 32'h1);
    @(negedge clk); fault_vld = 1'b0; rd_en = 1'b0;
    #1 check("R8 no overflow", rd_data, fields(2'd2, 3'd1, 3'b010));
    check("R6 fetch exc", {30'd0, exc_req, exc_instr}, 32'h3);

    // R3 back-to-back faults, status already nonzero
    @(negedge clk); drive_fault(2'd0, 3'd3, 3'b000, 1'b0, 1'b1, 32'h0000_4000);
    @(negedge clk); drive_fault(2'd1, 3'd6, 3'b101, 1'b1, 1'b1, 32'h0000_5000);
    @(negedge clk); fault_vld = 1'b0;
    check("R7 grant after nf fault", {30'd0, exc_req, grant_full}, 32'h1);
    #1 check("R3 overflow back-to-back", rd_data, fields(2'd1, 3'd6, 3'b101) | 32'h1);
    rd_sel = 1'b1; #1 check("R4 last address", rd_data, 32'h0000_5000);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule